// File: doc/BRIEF.md
# SDRAM Burst Access Command Sequencer

This block turns single read or write requests into the command sequence that an SDRAM of the DDR2 kind expects. Each request names a bank, a row, a column, a direction and whether the row should be closed automatically once the burst is over. The sequencer keeps a table that holds, for every bank, whether a row is open and which one. An access to a row that is already open goes straight to the column command. An access to a bank with no open row starts with an activate. An access to a bank holding a different row first precharges that bank, then activates the new row.

Gaps between commands come from two configuration inputs: the precharge-to-activate delay and the activate-to-column delay. The burst length, 4 or 8 beats, comes from a third. All three are sampled when a request is accepted. The block pulses `done` once the data burst time of half the burst length has passed after the column command, and takes a new request on the cycle after that.

Top module: `burst_cmd_seq`

## Requirements
- R1: The command pins {csN,rasN,casN,weN} carry activate = 0011, read = 0101, write = 0100, precharge = 0010, and otherwise NOP = 0111. NOP is driven during reset and while idle, with bank and address at zero.
- R2: `reqReady` is high only while the block is idle, and stays high after reset. A request is accepted on a rising edge that sees both `reqValid` and `reqReady` high, and its fields are captured on that edge.
- R3: An access to a bank with no open row drives an activate on the cycle after acceptance, with `cmdBank` = bank and `cmdAddr` = row.
- R4: The column command follows the activate by max(`cfgActDelay`,1) cycles. NOP is driven in between.
- R5: On the column command, `cmdBank` = bank, `cmdAddr[9:0]` = column, `cmdAddr[10]` = the auto-precharge flag, and all other address bits are 0. A write uses the write code and a read uses the read code.
- R6: When the bank already holds the requested row, the column command is driven on the cycle after acceptance and no activate is issued.
- R7: When the bank holds a different row, a precharge with `cmdAddr[10]` = 0 and `cmdBank` = bank is driven on the cycle after acceptance. The activate follows max(`cfgPreDelay`,1) cycles later, and the access then continues as in R4.
- R8: A column command with auto-precharge set marks its bank closed, so the next access to that bank starts with an activate and no precharge. Without the flag, the row stays open.
- R9: `done` is high for exactly one cycle, 4 cycles after the column command when `cfgBurst8` = 1 and 2 cycles after it when `cfgBurst8` = 0. `reqReady` is high on the next cycle.
- R10: Changing the configuration inputs after acceptance has no effect on the access in progress.
- R11: Each bank tracks its open row on its own. Opening a row in one bank does not change the hit or miss outcome in any other bank.
- R12: Reset closes every bank, so the first access after reset to any bank starts with an activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAutoPre | input | 1 | Close the row after the burst |
| reqBank | input | 3 | Target bank |
| reqRow | input | 16 | Target row |
| reqCol | input | 10 | Starting column |
| cfgBurst8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| cfgActDelay | input | 4 | Activate-to-column gap in cycles (0 acts as 1) |
| cfgPreDelay | input | 4 | Precharge-to-activate gap in cycles (0 acts as 1) |
| cmdCsN | output | 1 | Chip select, active low |
| cmdRasN | output | 1 | Row strobe, active low |
| cmdCasN | output | 1 | Column strobe, active low |
| cmdWeN | output | 1 | Write enable, active low |
| cmdBank | output | 3 | Bank address on the command bus |
| cmdAddr | output | 16 | Row or column address on the command bus |
| done | output | 1 | One-cycle pulse when the burst time ends |

## Verification
The bench builds the block with its default parameters: eight banks, 16-bit rows, 10-bit columns and 4-bit delay fields. It sweeps both burst lengths and every delay setting from 0 to 3, which includes the zero and one cases that share the shortest gap. For each setting it runs a fixed request pattern that drives every bank through a first activation, a row hit, a row miss with auto-precharge, and a reopen after that close. A cycle-by-cycle model of command spacing predicts every command pin, bank and address value. Further runs change the configuration in the middle of an access, open rows in neighbouring banks, and reset while rows are open.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Command pin values {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } cmd_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // request accepted this cycle
    logic issuePre;  // drive precharge
    logic issueAct;  // drive activate
    logic issueCol;  // drive read or write
    logic finish;    // burst time elapsed
  } strobe_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             bankOpen,
  input  logic             rowHit,
  input  logic [DLY_W-1:0] actDly,
  input  logic [DLY_W-1:0] preDly,
  input  logic             burst8,
  output logic             reqReady,
  output strobe_t          strb
);

  localparam int BURST_CYC4 = 2;
  localparam int BURST_CYC8 = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_PWAIT, S_ACT, S_AWAIT, S_COL, S_BURST, S_DONE
  } state_e;

  state_e          state;
  logic [DLY_W-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (reqValid) begin
          if (!bankOpen)   state <= S_ACT;
          else if (rowHit) state <= S_COL;
          else             state <= S_PRE;
        end
        S_PRE: begin
          if (preDly <= DLY_W'(1)) state <= S_ACT;
          else begin
            waitCnt <= preDly - DLY_W'(2);
            state   <= S_PWAIT;
          end
        end
        S_PWAIT: begin
          if (waitCnt == '0) state <= S_ACT;
          else waitCnt <= waitCnt - DLY_W'(1);
        end
        S_ACT: begin
          if (actDly <= DLY_W'(1)) state <= S_COL;
          else begin
            waitCnt <= actDly - DLY_W'(2);
            state   <= S_AWAIT;
          end
        end
        S_AWAIT: begin
          if (waitCnt == '0) state <= S_COL;
          else waitCnt <= waitCnt - DLY_W'(1);
        end
        S_COL: begin
          waitCnt <= burst8 ? DLY_W'(BURST_CYC8 - 2) : DLY_W'(BURST_CYC4 - 2);
          state   <= S_BURST;
        end
        S_BURST: begin
          if (waitCnt == '0) state <= S_DONE;
          else waitCnt <= waitCnt - DLY_W'(1);
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign reqReady = (state == S_IDLE);

  always_comb begin
    strb          = '0;
    strb.capture  = (state == S_IDLE) && reqValid;
    strb.issuePre = (state == S_PRE);
    strb.issueAct = (state == S_ACT);
    strb.issueCol = (state == S_COL);
    strb.finish   = (state == S_DONE);
  end

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int DLY_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              reqWrite,
  input  logic              reqAutoPre,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              cfgBurst8,
  input  logic [DLY_W-1:0]  cfgActDelay,
  input  logic [DLY_W-1:0]  cfgPreDelay,
  output logic              bankOpen,
  output logic              rowHit,
  output logic [DLY_W-1:0]  actDly,
  output logic [DLY_W-1:0]  preDly,
  output logic              burst8,
  output logic [3:0]        cmdPins,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdAddr,
  output logic              done
);

  localparam int NBANK = 1 << BANK_W;

  logic [BANK_W-1:0] latBank;
  logic [ROW_W-1:0]  latRow;
  logic [COL_W-1:0]  latCol;
  logic              latWrite, latAp;

  logic             openVld [NBANK];
  logic [ROW_W-1:0] openRow [NBANK];
  logic [NBANK-1:0] matchVec;

  // Request and configuration capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latBank <= '0; latRow <= '0; latCol <= '0;
      latWrite <= 1'b0; latAp <= 1'b0;
      burst8 <= 1'b0; actDly <= '0; preDly <= '0;
    end else if (strb.capture) begin
      latBank  <= reqBank;
      latRow   <= reqRow;
      latCol   <= reqCol;
      latWrite <= reqWrite;
      latAp    <= reqAutoPre;
      burst8   <= cfgBurst8;
      actDly   <= cfgActDelay;
      preDly   <= cfgPreDelay;
    end
  end

  // Open-row table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NBANK; b++) begin
        openVld[b] <= 1'b0;
        openRow[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (latBank == BANK_W'(b)) begin
          if (strb.issueAct) begin
            openVld[b] <= 1'b1;
            openRow[b] <= latRow;
          end else if (strb.issuePre || (strb.issueCol && latAp)) begin
            openVld[b] <= 1'b0;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_match
    assign matchVec[g] = openVld[g] && (openRow[g] == reqRow);
  end

  assign bankOpen = openVld[reqBank];
  assign rowHit   = matchVec[reqBank];

  // Command and address mux
  logic [ROW_W-1:0] colAddr;
  always_comb begin
    colAddr                = '0;
    colAddr[COL_W-1:0]     = latCol;
    colAddr[AP_BIT]        = latAp;
  end

  always_comb begin
    cmdPins = CMD_NOP;
    cmdBank = '0;
    cmdAddr = '0;
    if (strb.issuePre) begin
      cmdPins = CMD_PRE;
      cmdBank = latBank;
    end else if (strb.issueAct) begin
      cmdPins = CMD_ACT;
      cmdBank = latBank;
      cmdAddr = latRow;
    end else if (strb.issueCol) begin
      cmdPins = latWrite ? CMD_WR : CMD_RD;
      cmdBank = latBank;
      cmdAddr = colAddr;
    end
  end

  assign done = strb.finish;

endmodule

// File: rtl/burst_cmd_seq.sv
module burst_cmd_seq
  import burst_seq_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int DLY_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqAutoPre,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              cfgBurst8,
  input  logic [DLY_W-1:0]  cfgActDelay,
  input  logic [DLY_W-1:0]  cfgPreDelay,
  output logic              cmdCsN,
  output logic              cmdRasN,
  output logic              cmdCasN,
  output logic              cmdWeN,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdAddr,
  output logic              done
);

  strobe_t          strb;
  logic             bankOpen, rowHit, burst8;
  logic [DLY_W-1:0] actDly, preDly;
  logic [3:0]       cmdPins;

  burst_seq_ctrl #(.DLY_W(DLY_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .bankOpen(bankOpen), .rowHit(rowHit),
    .actDly(actDly), .preDly(preDly), .burst8(burst8),
    .reqReady(reqReady), .strb(strb)
  );

  burst_seq_dp #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT), .DLY_W(DLY_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqWrite(reqWrite), .reqAutoPre(reqAutoPre), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol),
    .cfgBurst8(cfgBurst8), .cfgActDelay(cfgActDelay), .cfgPreDelay(cfgPreDelay),
    .bankOpen(bankOpen), .rowHit(rowHit),
    .actDly(actDly), .preDly(preDly), .burst8(burst8),
    .cmdPins(cmdPins), .cmdBank(cmdBank), .cmdAddr(cmdAddr), .done(done)
  );

  assign {cmdCsN, cmdRasN, cmdCasN, cmdWeN} = cmdPins;

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ROW_W  = 16,
  parameter int AP_BIT = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             cmdCsN,
  input logic             cmdRasN,
  input logic             cmdCasN,
  input logic             cmdWeN,
  input logic [ROW_W-1:0] cmdAddr,
  input logic             done
);

  logic [3:0] pins;
  logic isNop, isAct, isPre, isCol;
  assign pins  = {cmdCsN, cmdRasN, cmdCasN, cmdWeN};
  assign isNop = (pins == 4'b0111);
  assign isAct = (pins == 4'b0011);
  assign isPre = (pins == 4'b0010);
  assign isCol = (pins == 4'b0101) || (pins == 4'b0100);

  p_legal_cmd_r1: assert property (@(posedge clk) disable iff (!rstN)
    pins inside {4'b0111, 4'b0011, 4'b0101, 4'b0100, 4'b0010});

  p_idle_nop_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> isNop);

  p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqReady && !isNop));

  p_act_next_r4: assert property (@(posedge clk) disable iff (!rstN)
    isAct |=> (!isAct && !isPre));

  p_col_upper_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> (cmdAddr >> (AP_BIT + 1)) == '0);

  p_pre_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> !cmdAddr[AP_BIT]);

  p_pre_next_r7: assert property (@(posedge clk) disable iff (!rstN)
    isPre |=> (!isCol && !isPre));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady));

endmodule

bind burst_cmd_seq burst_seq_chk #(.ROW_W(ROW_W), .AP_BIT(AP_BIT)) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .cmdCsN(cmdCsN), .cmdRasN(cmdRasN), .cmdCasN(cmdCasN), .cmdWeN(cmdWeN),
  .cmdAddr(cmdAddr), .done(done)
);

// File: tb/test_burst_cmd_seq.sv
`timescale 1ns/1ps
module test_burst_cmd_seq;

  localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD = 4'b0101,
                         K_WR = 4'b0100, K_PRE = 4'b0010;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, reqValid, reqReady, reqWrite, reqAutoPre;
  logic [2:0] reqBank;
  logic [15:0] reqRow;
  logic [9:0] reqCol;
  logic cfgBurst8;
  logic [3:0] cfgActDelay, cfgPreDelay;
  logic cmdCsN, cmdRasN, cmdCasN, cmdWeN;
  logic [2:0] cmdBank;
  logic [15:0] cmdAddr;
  logic done;

  burst_cmd_seq i_burst_cmd_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAutoPre(reqAutoPre), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .cfgBurst8(cfgBurst8),
    .cfgActDelay(cfgActDelay), .cfgPreDelay(cfgPreDelay),
    .cmdCsN(cmdCsN), .cmdRasN(cmdRasN), .cmdCasN(cmdCasN), .cmdWeN(cmdWeN),
    .cmdBank(cmdBank), .cmdAddr(cmdAddr), .done(done)
  );

  int nTests = 0, nFail = 0;

  // Bench model of the open-row state
  bit          mVld [8];
  logic [15:0] mRow [8];

  // Expected timeline of one access
  logic [3:0]  eCmd  [0:31];
  logic [2:0]  eBank [0:31];
  logic [15:0] eAddr [0:31];
  logic        eDone [0:31];
  string       eReq  [0:31];
  int          eLen;

  function automatic int eff(input logic [3:0] d);
    return (d == 4'd0) ? 1 : int'(d);
  endfunction

  task automatic check(input bit ok, input string msg);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic put(input logic [3:0] c, input logic [2:0] b, input logic [15:0] a,
                     input logic d, input string r);
    eCmd[eLen] = c; eBank[eLen] = b; eAddr[eLen] = a; eDone[eLen] = d; eReq[eLen] = r;
    eLen++;
  endtask

  task automatic access(input bit wr, input bit ap, input logic [2:0] b,
                        input logic [15:0] row, input logic [9:0] col,
                        input bit disturb, input string tag);
    int a, p, h;
    bit isOpen, isHit;
    logic sB8; logic [3:0] sA, sP;
    a = eff(cfgActDelay); p = eff(cfgPreDelay); h = cfgBurst8 ? 4 : 2;
    isOpen = mVld[b];
    isHit  = mVld[b] && (mRow[b] == row);
    eLen = 0;
    if (isOpen && !isHit) begin
      put(K_PRE, b, 16'h0000, 1'b0, "R7");
      for (int i = 1; i < p; i++) put(K_NOP, 3'd0, 16'h0000, 1'b0, "R7");
    end
    if (!isHit) begin
      put(K_ACT, b, row, 1'b0, isOpen ? "R7" : "R3");
      for (int i = 1; i < a; i++) put(K_NOP, 3'd0, 16'h0000, 1'b0, "R4");
      mVld[b] = 1'b1; mRow[b] = row;
    end
    put(wr ? K_WR : K_RD, b, {5'b0, ap, col}, 1'b0, isHit ? "R6" : "R5");
    if (ap) mVld[b] = 1'b0;
    for (int i = 1; i < h; i++) put(K_NOP, 3'd0, 16'h0000, 1'b0, "R9");
    put(K_NOP, 3'd0, 16'h0000, 1'b1, "R9");

    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAutoPre = ap;
    reqBank = b; reqRow = row; reqCol = col;
    @(negedge clk);
    reqValid = 1'b0;
    sB8 = cfgBurst8; sA = cfgActDelay; sP = cfgPreDelay;
    if (disturb) begin
      cfgBurst8 = ~cfgBurst8; cfgActDelay = sA + 4'd5; cfgPreDelay = sP + 4'd6;
      reqBank = ~b; reqRow = ~row; reqCol = ~col; reqWrite = ~wr; reqAutoPre = ~ap;
    end
    for (int i = 0; i < eLen; i++) begin
      check({cmdCsN, cmdRasN, cmdCasN, cmdWeN} == eCmd[i] && cmdBank == eBank[i] &&
            cmdAddr == eAddr[i] && done == eDone[i] && !reqReady,
            $sformatf("%s %s%s step %0d: actual cmd=%b bank=%0d addr=%h done=%b rdy=%b expected cmd=%b bank=%0d addr=%h done=%b rdy=0",
                      eReq[i], tag, disturb ? " R10" : "", i,
                      {cmdCsN, cmdRasN, cmdCasN, cmdWeN}, cmdBank, cmdAddr, done, reqReady,
                      eCmd[i], eBank[i], eAddr[i], eDone[i]));
      @(negedge clk);
    end
    check(reqReady && !done && {cmdCsN, cmdRasN, cmdCasN, cmdWeN} == K_NOP,
          $sformatf("R9 ready after done: actual rdy=%b done=%b expected rdy=1 done=0",
                    reqReady, done));
    cfgBurst8 = sB8; cfgActDelay = sA; cfgPreDelay = sP;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog R9: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int k;
    logic [15:0] rowA, rowB;
    logic [9:0] col;
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAutoPre = 1'b0;
    reqBank = '0; reqRow = '0; reqCol = '0;
    cfgBurst8 = 1'b0; cfgActDelay = 4'd2; cfgPreDelay = 4'd2;
    for (int b = 0; b < 8; b++) begin mVld[b] = 1'b0; mRow[b] = '0; end
    repeat (3) @(negedge clk);
    check({cmdCsN, cmdRasN, cmdCasN, cmdWeN} == K_NOP && cmdBank == 3'd0 &&
          cmdAddr == 16'h0 && !done,
          $sformatf("R1 reset NOP: actual cmd=%b bank=%0d addr=%h done=%b expected cmd=0111 0 0000 0",
                    {cmdCsN, cmdRasN, cmdCasN, cmdWeN}, cmdBank, cmdAddr, done));
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, $sformatf("R2 ready after reset: actual=%b expected=1", reqReady));

    // Sweep burst length and both delays
    for (int bl = 0; bl < 2; bl++)
      for (int ad = 0; ad < 4; ad++)
        for (int pd = 0; pd < 4; pd++) begin
          k = bl * 16 + ad * 4 + pd;
          cfgBurst8 = bl[0]; cfgActDelay = 4'(ad); cfgPreDelay = 4'(pd);
          rowA = 16'h1000 + 16'(k * 16'h0105);
          rowB = rowA ^ 16'h8421;
          col  = 10'(k * 37);
          access(1'b0, 1'b0, 3'(k % 8), rowA, col,        1'b0,           "R3");
          access(1'b1, 1'b0, 3'(k % 8), rowA, col + 10'd1, (k % 3) == 0,  "R6");
          access(1'b0, 1'b1, 3'(k % 8), rowB, col + 10'd2, 1'b0,          "R8");
          access(1'b1, 1'b0, 3'(k % 8), rowA, col + 10'd3, (k % 2) == 1,  "R8");
        end

    // Independent banks
    cfgBurst8 = 1'b1; cfgActDelay = 4'd3; cfgPreDelay = 4'd2;
    access(1'b0, 1'b0, 3'd5, 16'hBEEF, 10'h155, 1'b0, "R11");
    access(1'b1, 1'b0, 3'd6, 16'hCAFE, 10'h2AA, 1'b0, "R11");
    access(1'b0, 1'b0, 3'd4, 16'hBEEF, 10'h011, 1'b0, "R11");
    access(1'b0, 1'b0, 3'd5, 16'hBEEF, 10'h3FF, 1'b0, "R11");
    access(1'b1, 1'b0, 3'd6, 16'hCAFE, 10'h000, 1'b0, "R11");

    // Reset closes open rows
    access(1'b0, 1'b0, 3'd3, 16'h7777, 10'h123, 1'b0, "R12");
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int b = 0; b < 8; b++) mVld[b] = 1'b0;
    @(negedge clk);
    access(1'b0, 1'b0, 3'd3, 16'h7777, 10'h124, 1'b0, "R12");
    access(1'b1, 1'b0, 3'd5, 16'hBEEF, 10'h001, 1'b0, "R12");

    finishRun();
  end

endmodule